// File: doc/BRIEF.md
# Three-Wire Serial Word Memory Slave

This block is the slave side of a three-wire serial memory: select, serial clock, data in, plus a data-out line with its own drive enable so that it can be tri-stated outside the chip. Behind the interface sits a 64 x 16-bit array built from registers. The block runs on a fast system clock and samples the serial pins on it. It finds rising serial-clock edges by comparing each sample with the one before.

A host raises select and clocks in a frame. The frame is a 1 start bit, a 2-bit opcode and a 6-bit word address. Leading zeros before the start bit are skipped. The commands are:

- read a word
- write a page of up to eight words
- erase a word
- erase the whole array
- fill the whole array with one word
- allow writes
- block writes

Changes to the array are staged and applied only when select falls. A programming timer then holds the block busy for a fixed number of clock cycles. While it is busy, reselecting the block turns data-out into a ready/busy flag, and any frame sent in that window is ignored.

Top module: `mw_eeprom`

## Requirements
- R1: After reset the data-out enable is low, writes are blocked and every word reads as 16'hFFFF.
- R2: Read (opcode 2'b10): the data-out enable rises and data-out drives a 0 on the serial-clock rise that takes the last address bit. On each later rise it drives the addressed word, MSB first.
- R3: A write (opcode 2'b01) changes the array only when select falls, and only for 16-bit words that were received in full. A word cut short by select falling is discarded.
- R4: Words after the first one in a write go to consecutive addresses. Only the low 3 address bits advance, wrapping from 7 to 0, so the ninth word overwrites the first word's slot in the same eight-word page. Words outside the page are untouched.
- R5: Write, erase and whole-array commands have no effect while writes are blocked. Writes are blocked at reset and by opcode 2'b00 with address bits [5:4] = 2'b00. They are allowed by opcode 2'b00 with bits [5:4] = 2'b11.
- R6: Erase (opcode 2'b11) sets the addressed word to 16'hFFFF.
- R7: Opcode 2'b00 with address bits [5:4] = 2'b10 sets every word to 16'hFFFF.
- R8: Opcode 2'b00 with address bits [5:4] = 2'b01, followed by one data word, writes that word to every address.
- R9: Every applied change keeps the block busy for PROG_CYCLES clock cycles after select falls. If the block is selected during that time, data-out is enabled and reads 0 while busy. It turns to 1 when done and stays 1 while select stays high, with no serial clock needed.
- R10: A frame clocked in while the block is busy is ignored.
- R11: Zeros clocked in before the start bit are ignored.
- R12: The data-out enable is low whenever select is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock; serial pins are sampled on it |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Select, active high |
| sk_i | input | 1 | Serial clock |
| di_i | input | 1 | Serial data in |
| do_o | output | 1 | Serial data out / ready flag |
| do_en_o | output | 1 | Drive enable for data out |

## Verification
The bench makes a page write start mid-page and run past eight words. A design that fails to wrap, or that advances the upper address bits, would change words outside the page or leave the first slot with stale data. It cuts a write short partway through a word. A block that commits partial words would show a changed value. It sends a full write frame while the block is still busy, and checks that nothing changes. It measures the busy window from the select fall, so an off-by-some-cycles timer or a flag that drops out without the serial clock is caught. It also checks the dummy zero before read data, since a design that skips it returns the word shifted by one bit.

// File: rtl/mw_pkg.sv
package mw_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_HDR, ST_RD, ST_WR, ST_HOLD, ST_STAT} mw_state_e;
  typedef enum logic [2:0] {OP_NONE, OP_PAGE, OP_ERASE, OP_ERAL, OP_WRAL} mw_pend_e;
endpackage

// File: rtl/mw_store.sv
module mw_store
  import mw_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int PAGE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pg_clr_i,
  input  logic              pg_wr_i,
  input  logic [PAGE_W-1:0] pg_idx_i,
  input  logic [DATA_W-1:0] pg_data_i,
  input  logic              commit_i,
  input  mw_pend_e          commit_op_i,
  input  logic [ADDR_W-1:0] commit_addr_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAGE  = 1 << PAGE_W;

  logic [DATA_W-1:0]       page_q [PAGE];
  logic [PAGE-1:0]         vld_q;
  logic [DEPTH*DATA_W-1:0] flat;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      for (int i = 0; i < PAGE; i++) page_q[i] <= '0;
    end else if (pg_clr_i) begin
      vld_q <= '0;
    end else if (pg_wr_i) begin
      page_q[pg_idx_i] <= pg_data_i;
      vld_q[pg_idx_i]  <= 1'b1;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    localparam logic [ADDR_W-1:0] IA = ADDR_W'(g);
    logic [DATA_W-1:0] word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) word_q <= '1;
      else if (commit_i) begin
        unique case (commit_op_i)
          OP_PAGE:  if (IA[ADDR_W-1:PAGE_W] == commit_addr_i[ADDR_W-1:PAGE_W] &&
                        vld_q[IA[PAGE_W-1:0]])
                      word_q <= page_q[IA[PAGE_W-1:0]];
          OP_ERASE: if (IA == commit_addr_i) word_q <= '1;
          OP_ERAL:  word_q <= '1;
          OP_WRAL:  word_q <= page_q[0];
          default:  ;
        endcase
      end
    end
    assign flat[g*DATA_W +: DATA_W] = word_q;
  end

  assign rd_data_o = flat[rd_addr_i*DATA_W +: DATA_W];

  // R3
  mem_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable(flat));
endmodule

// File: rtl/mw_busy.sv
module mw_busy #(
  parameter int PROG_CYCLES = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int CW = $clog2(PROG_CYCLES + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (start_i)       cnt_q <= CW'(PROG_CYCLES);
    else if (cnt_q != '0)   cnt_q <= cnt_q - CW'(1);
  end

  assign busy_o = (cnt_q != '0);

  // R9
  busy_countdown_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !start_i |=> cnt_q == $past(cnt_q) - CW'(1));
endmodule

// File: rtl/mw_ctrl.sv
module mw_ctrl
  import mw_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int PAGE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              sk_i,
  input  logic              di_i,
  input  logic              busy_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              pg_clr_o,
  output logic              pg_wr_o,
  output logic [PAGE_W-1:0] pg_idx_o,
  output logic [DATA_W-1:0] pg_data_o,
  output logic              commit_o,
  output mw_pend_e          commit_op_o,
  output logic [ADDR_W-1:0] commit_addr_o,
  output logic              do_o,
  output logic              do_en_o
);
  localparam int HDR_W = ADDR_W + 2;
  localparam int CNT_W = $clog2(DATA_W);

  mw_state_e         state_q;
  mw_pend_e          pend_q;
  logic              cs_q, sk_q, wen_q, wral_q, dout_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [HDR_W-2:0]  hdr_q;
  logic [DATA_W-1:0] sh_q;
  logic [ADDR_W-1:0] addr_q;
  logic [PAGE_W-1:0] ptr_q;

  logic             sk_rise, cs_fall, hdr_done, word_done;
  logic [HDR_W-1:0] hdr_full;

  assign sk_rise   = cs_i & sk_i & ~sk_q;
  assign cs_fall   = cs_q & ~cs_i;
  assign hdr_full  = {hdr_q, di_i};
  assign hdr_done  = (state_q == ST_HDR) && sk_rise && cnt_q == CNT_W'(HDR_W - 1);
  assign word_done = (state_q == ST_WR) && sk_rise && cnt_q == CNT_W'(DATA_W - 1);

  assign rd_addr_o     = hdr_full[ADDR_W-1:0];
  assign pg_clr_o      = hdr_done;
  assign pg_wr_o       = word_done;
  assign pg_idx_o      = ptr_q;
  assign pg_data_o     = {sh_q[DATA_W-2:0], di_i};
  assign commit_o      = cs_fall && pend_q != OP_NONE && wen_q;
  assign commit_op_o   = pend_q;
  assign commit_addr_o = addr_q;
  assign do_o          = (state_q == ST_STAT) ? ~busy_i : dout_q;
  assign do_en_o       = cs_i && (state_q == ST_RD || state_q == ST_STAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;  pend_q <= OP_NONE;
      cs_q <= 1'b0;  sk_q <= 1'b0;  wen_q <= 1'b0;  wral_q <= 1'b0;  dout_q <= 1'b0;
      cnt_q <= '0;  hdr_q <= '0;  sh_q <= '0;  addr_q <= '0;  ptr_q <= '0;
    end else begin
      cs_q <= cs_i;
      sk_q <= sk_i;
      if (!cs_i) begin
        state_q <= ST_IDLE;
        pend_q  <= OP_NONE;
        cnt_q   <= '0;
      end else begin
        unique case (state_q)
          ST_IDLE: begin
            if (busy_i) state_q <= ST_STAT;     // reselect while programming
            else if (sk_rise && di_i) begin
              state_q <= ST_HDR;
              cnt_q   <= '0;
            end
          end
          ST_HDR: if (sk_rise) begin
            hdr_q <= hdr_full[HDR_W-2:0];
            cnt_q <= cnt_q + CNT_W'(1);
            if (hdr_done) begin
              cnt_q  <= '0;
              addr_q <= hdr_full[ADDR_W-1:0];
              unique case (hdr_full[HDR_W-1 -: 2])
                2'b10: begin state_q <= ST_RD; sh_q <= rd_data_i; dout_q <= 1'b0; end
                2'b01: begin state_q <= ST_WR; ptr_q <= hdr_full[PAGE_W-1:0]; wral_q <= 1'b0; end
                2'b11: begin state_q <= ST_HOLD; pend_q <= OP_ERASE; end
                default: begin
                  state_q <= ST_HOLD;
                  unique case (hdr_full[ADDR_W-1 -: 2])
                    2'b11: wen_q  <= 1'b1;
                    2'b00: wen_q  <= 1'b0;
                    2'b10: pend_q <= OP_ERAL;
                    default: begin state_q <= ST_WR; ptr_q <= '0; wral_q <= 1'b1; end
                  endcase
                end
              endcase
            end
          end
          ST_RD: if (sk_rise) begin
            dout_q <= sh_q[DATA_W-1];
            sh_q   <= {sh_q[DATA_W-2:0], 1'b0};
          end
          ST_WR: if (sk_rise) begin
            sh_q  <= {sh_q[DATA_W-2:0], di_i};
            cnt_q <= cnt_q + CNT_W'(1);
            if (word_done) begin
              cnt_q  <= '0;
              ptr_q  <= ptr_q + PAGE_W'(1);
              pend_q <= wral_q ? OP_WRAL : OP_PAGE;
              if (wral_q) state_q <= ST_HOLD;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R10
  hdr_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_HDR |-> !busy_i);
  // R2
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_RD && !sk_rise |=> $stable(dout_q));
endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom
  import mw_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int PAGE_W      = 3,
  parameter int PROG_CYCLES = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_i,
  input  logic sk_i,
  input  logic di_i,
  output logic do_o,
  output logic do_en_o
);
  logic              busy, pg_clr, pg_wr, commit;
  logic [PAGE_W-1:0] pg_idx;
  logic [DATA_W-1:0] pg_data, rd_data;
  logic [ADDR_W-1:0] rd_addr, commit_addr;
  mw_pend_e          commit_op;

  mw_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_ctrl (
    .clk_i, .rst_ni, .cs_i, .sk_i, .di_i,
    .busy_i(busy), .rd_data_i(rd_data), .rd_addr_o(rd_addr),
    .pg_clr_o(pg_clr), .pg_wr_o(pg_wr), .pg_idx_o(pg_idx), .pg_data_o(pg_data),
    .commit_o(commit), .commit_op_o(commit_op), .commit_addr_o(commit_addr),
    .do_o, .do_en_o
  );

  mw_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_store (
    .clk_i, .rst_ni,
    .pg_clr_i(pg_clr), .pg_wr_i(pg_wr), .pg_idx_i(pg_idx), .pg_data_i(pg_data),
    .commit_i(commit), .commit_op_i(commit_op), .commit_addr_i(commit_addr),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  mw_busy #(.PROG_CYCLES(PROG_CYCLES)) u_busy (
    .clk_i, .rst_ni, .start_i(commit), .busy_o(busy)
  );

  // R9
  commit_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |=> busy);
endmodule

// File: tb/tb_mw_eeprom.sv
`timescale 1ns/1ps
module tb_mw_eeprom;
  localparam int PROG = 200;

  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic dout, den;
  int   n_chk = 0, n_fail = 0, cyc = 0, t_fall = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mw_eeprom #(.PROG_CYCLES(PROG)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .sk_i(sk), .di_i(di),
    .do_o(dout), .do_en_o(den)
  );

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic bit_out(input logic b);
    @(negedge clk); di = b; sk = 1'b0;
    repeat (3) @(negedge clk);
    sk = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic sel();
    @(negedge clk); cs = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic desel();
    @(negedge clk); sk = 1'b0; cs = 1'b0; t_fall = cyc;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_hdr(input logic [1:0] op, input logic [5:0] a);
    bit_out(1'b1);
    for (int i = 1; i >= 0; i--) bit_out(op[i]);
    for (int i = 5; i >= 0; i--) bit_out(a[i]);
  endtask

  task automatic send_word(input logic [15:0] d, input int nbits = 16);
    for (int i = 15; i > 15 - nbits; i--) bit_out(d[i]);
  endtask

  task automatic read_chk(input logic [5:0] a, input logic [15:0] exp, input string req, input int nlead = 0);
    logic [15:0] got = '0;
    sel();
    for (int i = 0; i < nlead; i++) bit_out(1'b0);
    send_hdr(2'b10, a);
    check(den === 1'b1 && dout === 1'b0, "R2 dummy bit", {30'd0, den, dout}, 32'h2);
    for (int i = 0; i < 16; i++) begin
      bit_out(1'b0);
      got = {got[14:0], dout};
    end
    check(got === exp, req, {16'd0, got}, {16'd0, exp});
    desel();
    check(den === 1'b0, "R12 enable low when deselected", {31'd0, den}, 32'd0);
  endtask

  task automatic wait_ready(input logic timed);
    int n = 0;
    int t;
    sel();
    check(den === 1'b1 && dout === 1'b0, "R9 busy flag", {30'd0, den, dout}, 32'h2);
    while (dout !== 1'b1 && n < PROG + 50) begin
      @(negedge clk); n++;
    end
    t = cyc - t_fall;
    if (timed) check(t >= PROG - 2 && t <= PROG + 6, "R9 busy duration", t, PROG);
    repeat (10) @(negedge clk);
    check(den === 1'b1 && dout === 1'b1, "R9 ready held", {30'd0, den, dout}, 32'h3);
    desel();
  endtask

  task automatic special(input logic [1:0] sub);
    sel(); send_hdr(2'b00, {sub, 4'b0000}); desel();
  endtask

  task automatic t_reset();
    check(den === 1'b0, "R1 reset enable", {31'd0, den}, 32'd0);
    read_chk(6'd5, 16'hFFFF, "R1 reset contents");
    read_chk(6'd63, 16'hFFFF, "R1 reset contents top");
  endtask

  task automatic t_blocked();
    sel(); send_hdr(2'b01, 6'd3); send_word(16'h1234); desel();
    sel();
    check(den === 1'b0, "R5 no busy when blocked", {31'd0, den}, 32'd0);
    desel();
    read_chk(6'd3, 16'hFFFF, "R5 write ignored after reset");
  endtask

  task automatic t_write();
    special(2'b11);
    sel(); send_hdr(2'b01, 6'd3); send_word(16'hA5C3); desel();
    wait_ready(1'b1);
    read_chk(6'd3, 16'hA5C3, "R3 single write", 2);
    sel(); send_hdr(2'b01, 6'd4); send_word(16'h0F0F, 10); desel();
    sel();
    check(den === 1'b0, "R3 partial word no commit", {31'd0, den}, 32'd0);
    desel();
    read_chk(6'd4, 16'hFFFF, "R3 partial word discarded");
  endtask

  task automatic t_page();
    sel(); send_hdr(2'b01, 6'h0E);
    for (int k = 0; k < 10; k++) send_word(16'hC000 + 16'(k));
    desel();
    wait_ready(1'b1);
    for (int s = 0; s < 8; s++) begin
      int k = (s == 6) ? 8 : (s == 7) ? 9 : s + 2;
      read_chk(6'(8 + s), 16'hC000 + 16'(k), "R4 page wrap");
    end
    read_chk(6'd16, 16'hFFFF, "R4 next page untouched");
    read_chk(6'd7, 16'hFFFF, "R4 previous page untouched");
  endtask

  task automatic t_busy_ignore();
    sel(); send_hdr(2'b01, 6'd20); send_word(16'h1111); desel();
    sel(); send_hdr(2'b01, 6'd21); send_word(16'h2222); desel();
    wait_ready(1'b0);
    read_chk(6'd21, 16'hFFFF, "R10 frame during busy ignored");
    read_chk(6'd20, 16'h1111, "R10 earlier write kept");
  endtask

  task automatic t_erase();
    sel(); send_hdr(2'b11, 6'd3); desel();
    wait_ready(1'b1);
    read_chk(6'd3, 16'hFFFF, "R6 erase word");
    read_chk(6'd20, 16'h1111, "R6 other word kept");
  endtask

  task automatic t_all();
    sel(); send_hdr(2'b00, 6'b010000); send_word(16'h5A5A); desel();
    wait_ready(1'b1);
    read_chk(6'd0, 16'h5A5A, "R8 fill low");
    read_chk(6'd63, 16'h5A5A, "R8 fill high");
    special(2'b10);
    wait_ready(1'b1);
    read_chk(6'd0, 16'hFFFF, "R7 erase all low");
    read_chk(6'd40, 16'hFFFF, "R7 erase all mid");
  endtask

  task automatic t_disable();
    special(2'b00);
    sel(); send_hdr(2'b01, 6'd1); send_word(16'h0000); desel();
    sel(); send_hdr(2'b11, 6'd2); desel();
    read_chk(6'd1, 16'hFFFF, "R5 write ignored after disable");
    read_chk(6'd9, 16'hFFFF, "R11 leading zeros", 3);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_blocked();
    t_write();
    t_page();
    t_busy_ignore();
    t_erase();
    t_all();
    t_disable();
    finish_up();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_up();
  end
endmodule